// File: doc/BRIEF.md
# Power-Management Event Status, Enable and Interval Timer

This block holds a pair of power-management event registers (a sticky status word and a matching enable word) next to a free-running interval counter, and drives a level-sensitive system control interrupt (SCI). Software reaches the three registers through a small byte-addressed register port. The status word is cleared by writing ones. Hardware sets its bits from four sources: a power-button request, a real-time-clock alarm, a global-lock release and the timer's own half-range crossing.

The counter advances on a tick-enable input, so its rate does not depend on the system clock. Its low `CNT_W` bits can be read back. The timer source fires each time the count reaches the next multiple of half the readable range. The tracker that detects this is re-armed whenever software acknowledges a pending timer event. The SCI line stays high for as long as any source has both its status bit and its enable bit set.

Top module: `pm_event_timer`

## Requirements
- R1: After reset the status word, the enable word and the counter are all zero, and the timer overflow point is zero. The timer status bit therefore sets on the first clock edge after reset is released.
- R2: Byte offset 0x00 selects status, 0x02 selects enable and 0x08 selects the timer. Any other offset reads as 0, and a write to it changes nothing. A write to the timer offset also changes nothing.
- R3: In both status and enable, the timer source is bit 0, global lock is bit 5, power button is bit 8 and RTC is bit 10. Every other bit reads 0 and cannot be written.
- R4: A write to the enable offset stores the written value of each implemented bit on the next clock edge.
- R5: A write to the status offset clears each implemented bit written as 1 and leaves each bit written as 0 unchanged.
- R6: The counter increments by one on every clock edge where `tick_en` is high and holds otherwise. It wraps modulo 2^CNT_W, and the timer offset returns it zero-extended.
- R7: The timer status bit sets on the edge after the counter reaches the overflow point, which is a multiple of 2^(CNT_W-1). Setting it never stops or resets the count.
- R8: Clearing a timer status bit that is set moves the overflow point to the next multiple of 2^(CNT_W-1) strictly above the current count. Writing 1 to an already clear timer bit leaves the overflow point where it was.
- R9: A `pwr_req` cycle sets status bit 8 only while enable bit 8 is set. Otherwise it has no effect.
- R10: `rtc_evt` sets status bit 10 and `glk_evt` sets status bit 5, whatever the enable word holds.
- R11: When a hardware set and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R12: `sci` is high exactly while status AND enable is non-zero over bits 0, 5, 8 and 10. It follows the registers in the same cycle they change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Advance the interval counter this cycle |
| pwr_req | input | 1 | Power-button request |
| rtc_evt | input | 1 | Real-time-clock alarm event |
| glk_evt | input | 1 | Global-lock release event |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe for the register at `bus_addr` |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | RD_W | Read data for `bus_addr`, combinational |
| sci | output | 1 | Level interrupt request |

## Verification
The assertions assume that every input is synchronous to `clk` and settled at the rising edge. The power-button property also assumes that `pwr_req` is the only source of bit 8. The unmapped-read property assumes that read data depends only on the current offset, with no read strobe. The stimulus changes inputs just after the falling edge. It builds the block with an 8-bit counter so that the half-range crossings, the wrap and the re-arming come within reach. It stops and starts `tick_en` at chosen counts so that each acknowledgment lands in a known half of the range.

// File: rtl/pm_evt_pkg.sv
`timescale 1ns/1ps
package pm_evt_pkg;

   // register word width shared by status, enable and write data
   localparam int unsigned REG_W   = 16;

   // source bit positions (R3), shared by status and enable
   localparam int unsigned TMR_BIT = 0;
   localparam int unsigned GLK_BIT = 5;
   localparam int unsigned PWR_BIT = 8;
   localparam int unsigned RTC_BIT = 10;

   typedef logic [REG_W-1:0] reg_t;

   localparam reg_t SRC_MASK = reg_t'((32'd1 << TMR_BIT) | (32'd1 << GLK_BIT) |
                                      (32'd1 << PWR_BIT) | (32'd1 << RTC_BIT));

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_STS,
      SEL_EN,
      SEL_TMR
   } rd_sel_e;

   typedef struct packed {
      logic sts_wr;
      logic en_wr;
   } wr_strb_t;

endpackage

// File: rtl/pm_reg_decode.sv
`timescale 1ns/1ps
// Offset decode for the three registers (R2).
module pm_reg_decode
   import pm_evt_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned STS_OFS = 0,
   parameter int unsigned EN_OFS  = 2,
   parameter int unsigned TMR_OFS = 8
)(
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   output rd_sel_e           sel,
   output wr_strb_t          strb
);

   localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(STS_OFS);
   localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(EN_OFS);
   localparam logic [ADDR_W-1:0] A_TMR = ADDR_W'(TMR_OFS);

   always_comb begin
      if (addr == A_STS)      sel = SEL_STS;
      else if (addr == A_EN)  sel = SEL_EN;
      else if (addr == A_TMR) sel = SEL_TMR;
      else                    sel = SEL_NONE;
   end

   // the timer offset is read-only: no strobe is ever produced for it
   always_comb begin
      strb.sts_wr = wr && (sel == SEL_STS);
      strb.en_wr  = wr && (sel == SEL_EN);
   end

endmodule

// File: rtl/pm_tick_counter.sv
`timescale 1ns/1ps
// Free-running interval counter plus overflow-point tracker (R6, R7, R8).
// The overflow point is always a multiple of half the counter range, so it
// is held as the value the counter's top bit takes at that point.
module pm_tick_counter #(
   parameter int unsigned CNT_W = 24
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             recalc,
   output logic [CNT_W-1:0] count_q,
   output logic             tgt_half_q,
   output logic             reached
);

   localparam int unsigned MSB = CNT_W - 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count_q <= '0;
      else if (tick_en) count_q <= count_q + CNT_W'(1);
   end

   // reset puts the point at zero; re-arming picks the next half-range
   // boundary strictly above the present count
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tgt_half_q <= 1'b0;
      else if (recalc) tgt_half_q <= ~count_q[MSB];
   end

   assign reached = (count_q[MSB] == tgt_half_q);

endmodule

// File: rtl/pm_evt_status.sv
`timescale 1ns/1ps
// Status (write-one-to-clear) and enable words, one cell per implemented bit.
module pm_evt_status
   import pm_evt_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  wr_strb_t strb,
   input  reg_t     wdata,
   input  logic     tmr_reached,
   input  logic     pwr_req,
   input  logic     rtc_evt,
   input  logic     glk_evt,
   output reg_t     sts_q,
   output reg_t     en_q,
   output logic     recalc
);

   wire [REG_W-1:0] sts_w;
   wire [REG_W-1:0] en_w;
   reg_t            set_v;
   reg_t            clr_v;

   // hardware set sources (R7, R9, R10)
   always_comb begin
      set_v          = '0;
      set_v[TMR_BIT] = tmr_reached & ~sts_w[TMR_BIT];
      set_v[PWR_BIT] = pwr_req & en_w[PWR_BIT];
      set_v[RTC_BIT] = rtc_evt;
      set_v[GLK_BIT] = glk_evt;
   end

   assign clr_v  = strb.sts_wr ? wdata : '0;
   // re-arm only when a pending timer event is acknowledged (R8)
   assign recalc = clr_v[TMR_BIT] & sts_w[TMR_BIT];

   for (genvar b = 0; b < REG_W; b++) begin : g_bit
      if (SRC_MASK[b]) begin : g_impl
         logic s_q;
         logic e_q;
         // set wins over a same-cycle clear (R11); R5 clear of ones only
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s_q <= 1'b0;
               e_q <= 1'b0;
            end else begin
               s_q <= (s_q & ~clr_v[b]) | set_v[b];
               if (strb.en_wr) e_q <= wdata[b];
            end
         end
         assign sts_w[b] = s_q;
         assign en_w[b]  = e_q;
      end else begin : g_rsvd
         assign sts_w[b] = 1'b0;
         assign en_w[b]  = 1'b0;
      end
   end

   assign sts_q = sts_w;
   assign en_q  = en_w;

endmodule

// File: rtl/pm_event_timer.sv
`timescale 1ns/1ps
module pm_event_timer
   import pm_evt_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned RD_W    = 32,
   parameter int unsigned CNT_W   = 24,
   parameter int unsigned STS_OFS = 0,
   parameter int unsigned EN_OFS  = 2,
   parameter int unsigned TMR_OFS = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              pwr_req,
   input  logic              rtc_evt,
   input  logic              glk_evt,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [RD_W-1:0]   bus_rdata,
   output logic              sci
);

   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   initial begin
      assert (CNT_W >= 2 && CNT_W <= RD_W)
         else $error("CNT_W must lie in 2..RD_W");
      assert (RD_W >= REG_W)
         else $error("RD_W must hold a whole register word");
      assert (STS_OFS < ADDR_SPAN && EN_OFS < ADDR_SPAN && TMR_OFS < ADDR_SPAN)
         else $error("register offsets must fit in ADDR_W");
      assert (STS_OFS != EN_OFS && STS_OFS != TMR_OFS && EN_OFS != TMR_OFS)
         else $error("register offsets must be distinct");
   end

   rd_sel_e          sel;
   wr_strb_t         strb;
   reg_t             sts_q;
   reg_t             en_q;
   logic             recalc;
   logic             reached;
   logic [CNT_W-1:0] count_q;
   logic             tgt_half_q;

   pm_reg_decode #(
      .ADDR_W (ADDR_W),
      .STS_OFS(STS_OFS),
      .EN_OFS (EN_OFS),
      .TMR_OFS(TMR_OFS)
   ) u_dec (
      .addr(bus_addr),
      .wr  (bus_wr),
      .sel (sel),
      .strb(strb)
   );

   pm_tick_counter #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .recalc    (recalc),
      .count_q   (count_q),
      .tgt_half_q(tgt_half_q),
      .reached   (reached)
   );

   pm_evt_status u_sts (
      .clk        (clk),
      .rst_n      (rst_n),
      .strb       (strb),
      .wdata      (bus_wdata),
      .tmr_reached(reached),
      .pwr_req    (pwr_req),
      .rtc_evt    (rtc_evt),
      .glk_evt    (glk_evt),
      .sts_q      (sts_q),
      .en_q       (en_q),
      .recalc     (recalc)
   );

   // read path (R2, R6): unmapped offsets return zero
   always_comb begin
      case (sel)
         SEL_STS: bus_rdata = RD_W'(sts_q);
         SEL_EN:  bus_rdata = RD_W'(en_q);
         SEL_TMR: bus_rdata = RD_W'(count_q);
         default: bus_rdata = '0;
      endcase
   end

   // R12 level interrupt
   assign sci = |(sts_q & en_q & SRC_MASK);

endmodule

// File: rtl/pm_event_timer_chk.sv
`timescale 1ns/1ps
module pm_event_timer_chk
   import pm_evt_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned RD_W    = 32,
   parameter int unsigned CNT_W   = 24,
   parameter int unsigned STS_OFS = 0,
   parameter int unsigned EN_OFS  = 2,
   parameter int unsigned TMR_OFS = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              pwr_req,
   input logic              rtc_evt,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [REG_W-1:0]  bus_wdata,
   input logic [RD_W-1:0]   bus_rdata,
   input logic              sci,
   input reg_t              sts_q,
   input reg_t              en_q,
   input logic [CNT_W-1:0]  count_q,
   input logic              tgt_half_q
);

   localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(STS_OFS);
   localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(EN_OFS);
   localparam logic [ADDR_W-1:0] A_TMR = ADDR_W'(TMR_OFS);

   logic ack_tmr;
   assign ack_tmr = bus_wr && (bus_addr == A_STS) && bus_wdata[TMR_BIT] && sts_q[TMR_BIT];

   a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en |=> count_q == $past(count_q) + CNT_W'(1));

   a_r6_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(count_q));

   a_r5_w1c_timer: assert property (@(posedge clk) disable iff (!rst_n)
      ack_tmr |=> !sts_q[TMR_BIT]);

   a_r8_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      ack_tmr |=> tgt_half_q == !$past(count_q[CNT_W-1]));

   a_r9_pwr_gated: assert property (@(posedge clk) disable iff (!rst_n)
      ((!pwr_req || !en_q[PWR_BIT]) && !sts_q[PWR_BIT]) |=> !sts_q[PWR_BIT]);

   a_r10_rtc_sets: assert property (@(posedge clk) disable iff (!rst_n)
      rtc_evt |=> sts_q[RTC_BIT]);

   a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr != A_STS && bus_addr != A_EN && bus_addr != A_TMR) |-> bus_rdata == '0);

   a_r12_sci_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
      sci |-> $countones(sts_q & en_q) != 0);

endmodule

bind pm_event_timer pm_event_timer_chk #(
   .ADDR_W (ADDR_W),
   .RD_W   (RD_W),
   .CNT_W  (CNT_W),
   .STS_OFS(STS_OFS),
   .EN_OFS (EN_OFS),
   .TMR_OFS(TMR_OFS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_en   (tick_en),
   .pwr_req   (pwr_req),
   .rtc_evt   (rtc_evt),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .sci       (sci),
   .sts_q     (sts_q),
   .en_q      (en_q),
   .count_q   (count_q),
   .tgt_half_q(tgt_half_q)
);

// File: tb/tb_pm_event_timer.sv
`timescale 1ns/1ps
module tb_pm_event_timer;

   localparam int unsigned CNT_W = 8;
   localparam longint      HALF  = longint'(1) << (CNT_W - 1);
   localparam longint      WRAP  = longint'(1) << CNT_W;
   localparam int unsigned MASK  = 32'h0521;

   logic        clk       = 1'b0;
   logic        rst_n     = 1'b0;
   logic        tick_en   = 1'b0;
   logic        pwr_req   = 1'b0;
   logic        rtc_evt   = 1'b0;
   logic        glk_evt   = 1'b0;
   logic [3:0]  bus_addr  = 4'h0;
   logic        bus_wr    = 1'b0;
   logic [15:0] bus_wdata = 16'h0;
   logic [31:0] bus_rdata;
   logic        sci;

   always #5 clk = ~clk;

   pm_event_timer #(
      .ADDR_W(4),
      .RD_W  (32),
      .CNT_W (CNT_W)
   ) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .pwr_req  (pwr_req),
      .rtc_evt  (rtc_evt),
      .glk_evt  (glk_evt),
      .bus_addr (bus_addr),
      .bus_wr   (bus_wr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .sci      (sci)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   task automatic check(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int unsigned m_sts = 0;
   int unsigned m_en  = 0;
   longint      m_cnt = 0;   // unwrapped tick count
   longint      m_ovf = 0;   // absolute overflow point

   always @(posedge clk or negedge rst_n) begin : mdl
      int unsigned clr;
      int unsigned set;
      bit          hit;
      if (!rst_n) begin
         m_sts = 0;
         m_en  = 0;
         m_cnt = 0;
         m_ovf = 0;
      end else begin
         clr = (bus_wr && bus_addr == 4'h0) ? int'(bus_wdata) : 0;
         hit = ((m_sts & 1) == 0) && (m_cnt >= m_ovf);
         if ((clr & 1) != 0 && (m_sts & 1) != 0)
            m_ovf = ((m_cnt + HALF) / HALF) * HALF;
         set = 0;
         if (hit) set |= 32'h0001;
         if (pwr_req && (m_en & 32'h0100) != 0) set |= 32'h0100;
         if (rtc_evt) set |= 32'h0400;
         if (glk_evt) set |= 32'h0020;
         m_sts = ((m_sts & ~clr) | set) & MASK;
         if (bus_wr && bus_addr == 4'h2) m_en = int'(bus_wdata) & MASK;
         if (tick_en) m_cnt++;
      end
   end

   function automatic longint m_read(input logic [3:0] a);
      case (a)
         4'h0:    return longint'(m_sts);
         4'h2:    return longint'(m_en);
         4'h8:    return m_cnt % WRAP;
         default: return 0;
      endcase
   endfunction

   function automatic string read_tag(input logic [3:0] a);
      case (a)
         4'h0:    return "R5 status vs model";
         4'h2:    return "R4 enable vs model";
         4'h8:    return "R6 timer vs model";
         default: return "R2 unmapped vs model";
      endcase
   endfunction

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(read_tag(bus_addr), longint'(bus_rdata), m_read(bus_addr));
         check("R12 sci vs model", longint'(sci), longint'((m_sts & m_en & MASK) != 0));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic peek(input logic [3:0] a, output longint v);
      bus_addr = a;
      #1;
      v = longint'(bus_rdata);
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      step();
      bus_wr    = 1'b0;
   endtask

   task automatic run_to(input longint target);
      longint v;
      v = -1;
      for (int i = 0; i < 400; i++) begin
         peek(4'h8, v);
         if (v == target) return;
         step();
      end
      check("R6 counter reached target", v, target);
   endtask

   // ---------------- directed sequence ----------------
   initial begin
      longint v;
      repeat (3) @(negedge clk);
      #1;
      peek(4'h0, v); check("R1 status zero in reset", v, 0);
      peek(4'h2, v); check("R1 enable zero in reset", v, 0);
      peek(4'h8, v); check("R1 timer zero in reset", v, 0);
      check("R1 sci low in reset", longint'(sci), 0);
      rst_n = 1'b1;
      step();
      peek(4'h0, v); check("R1 timer status set from zero overflow point", v, 32'h0001);

      wr(4'h2, 16'hFFFF);
      peek(4'h2, v); check("R3 R4 enable keeps only implemented bits", v, 32'h0521);
      check("R12 sci from timer source", longint'(sci), 1);

      wr(4'h0, 16'h0000);
      peek(4'h0, v); check("R5 zeros written leave status", v, 32'h0001);
      wr(4'h0, 16'h0001);
      peek(4'h0, v); check("R5 one written clears status bit", v, 0);
      check("R12 sci low after clear", longint'(sci), 0);

      pwr_req = 1'b1; step(); pwr_req = 1'b0;
      peek(4'h0, v); check("R9 enabled power request sets bit 8", v, 32'h0100);
      wr(4'h2, 16'h0000);
      wr(4'h0, 16'hFFFF);
      pwr_req = 1'b1; step(); pwr_req = 1'b0;
      peek(4'h0, v); check("R9 disabled power request ignored", v, 0);

      rtc_evt = 1'b1; step(); rtc_evt = 1'b0;
      peek(4'h0, v); check("R10 rtc sets bit 10 with enable clear", v, 32'h0400);
      check("R12 sci low with source disabled", longint'(sci), 0);
      wr(4'h2, 16'h0400);
      check("R12 sci high once rtc enabled", longint'(sci), 1);

      glk_evt = 1'b1;
      wr(4'h0, 16'h0420);
      glk_evt = 1'b0;
      peek(4'h0, v); check("R11 set beats same-cycle clear", v, 32'h0020);

      wr(4'h4, 16'hFFFF);
      wr(4'h6, 16'hFFFF);
      wr(4'h8, 16'hFFFF);
      wr(4'hE, 16'hFFFF);
      peek(4'h0, v); check("R2 unmapped writes leave status", v, 32'h0020);
      peek(4'h2, v); check("R2 unmapped writes leave enable", v, 32'h0400);
      peek(4'h8, v); check("R2 timer offset is read-only", v, 0);
      peek(4'h4, v); check("R2 unmapped offset reads zero", v, 0);

      wr(4'h0, 16'hFFFF);
      wr(4'h2, 16'h0001);

      tick_en = 1'b1;
      repeat (5) step();
      peek(4'h8, v); check("R6 counter advances per tick", v, 5);

      run_to(HALF);
      peek(4'h0, v); check("R7 status not yet set on crossing edge", v, 0);
      step();
      peek(4'h0, v); check("R7 timer status set after crossing", v, 32'h0001);
      peek(4'h8, v); check("R7 count keeps running", v, HALF + 1);

      run_to(WRAP - 1);
      step();
      peek(4'h8, v); check("R6 counter wraps to zero", v, 0);

      run_to(40);
      tick_en = 1'b0;
      wr(4'h0, 16'h0001);
      peek(4'h0, v); check("R8 acknowledge clears timer status", v, 0);
      step(); step();
      peek(4'h0, v); check("R8 re-armed point lies ahead", v, 0);
      tick_en = 1'b1;
      run_to(HALF);
      step();
      peek(4'h0, v); check("R7 fires at re-armed point", v, 32'h0001);

      run_to(HALF + 22);
      tick_en = 1'b0;
      wr(4'h0, 16'h0001);
      step(); step();
      peek(4'h0, v); check("R8 no refire in upper half after re-arm", v, 0);
      tick_en = 1'b1;
      run_to(0);
      peek(4'h0, v); check("R8 status clear on wrap edge", v, 0);
      step();
      peek(4'h0, v); check("R8 fires at next boundary after wrap", v, 32'h0001);

      tick_en = 1'b0;
      step();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL R6 watchdog: actual 0x1 expected 0x0 (run did not end)");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule